// File: doc/BRIEF.md
# Tagged Instruction Memory Load Port

This block gives a host an indirect way to fill a microcontroller's instruction memory through a few registers. The host sets a port's address register with a start address and two session flags: auto-increment and secure. It then pushes 32-bit words through the port's data register, and each word is stored at the port's current address. When auto-increment is on, the address moves forward one word after each data access, whether the access is a read or a write. A third register in each port loads a tag into a small side array. That array has one entry for each 64-word (256-byte) block of instruction memory, and a tag write goes to the block that holds the port's current address.

Each data write also records the session's secure flag against the block it lands in. Several identical ports sit at a 16-byte register stride starting at 0x180, and all of them share the one memory. The loader pads each code image up to a 64-word boundary by writing zero words, and these are stored like any other data. When an address runs past the last word, it wraps to zero and sets a sticky overflow flag, which the host can read back in the address register.

Top module: `tagged_imem_load_top`

## Requirements
- R1: After reset, every port's address register and every tag register read back as 0.
- R2: A write to the address register (port offset 0) loads the byte address from bits [9:2] and ignores bits [1:0] and bits [23:10]. It takes auto-increment from bit 24 and the secure flag from bit 28, and it clears the overflow flag. A read returns the address in bits [9:2], auto-increment in bit 24, secure in bit 28 and overflow in bit 29, with every other bit 0.
- R3: A write to the data register (port offset 4) stores the word at the current address. With auto-increment set, the address then moves on by 4 bytes. With it clear, the address stays where it is and the next write overwrites the same word.
- R4: A read of any register returns its value on host_rdata, with host_rvalid high, in the cycle after the request. A data register read returns the word at the current address, and it advances the address when auto-increment is set.
- R5: A tag write (port offset 8) stores bits [15:0] into the entry for the 64-word block that holds the current address, even when that address is not aligned. It does not move the address. A tag read returns that block's tag in bits [15:0] and its secure attribute in bit 31.
- R6: Each data write sets the secure attribute of the block it lands in to the session's secure flag.
- R7: A data access with auto-increment at byte address 0x3FC (the last word) wraps the address to 0 and sets the overflow flag. The flag stays set until the next address-register write.
- R8: Port p is decoded at 0x180 + 16*p. An access to one port leaves every other port's address unchanged, and all ports share the same memory contents.
- R9: A zero data word is stored and advances the address like any other word, so padding writes overwrite whatever was there before.
- R10: A port offset other than 0, 4 or 8, or a bus address outside the port range, is ignored: a write changes no state and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| host_req | input | 1 | Register access request, one per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Register byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe, one cycle after a read request |

## Verification
On every cycle the assertions check how each port's address moves. The address steps by one word on an auto-increment data access and wraps to zero with the overflow flag set at the last word. It does not move when a different port is accessed. The overflow flag stays set, read responses arrive one cycle after the request, and unmapped reads return zero. Only the bench's scenarios can show where the data actually lands: what is stored at the address, which block a tag goes to, the secure attribute recorded per block, the effect of zero padding writes, and the fact that the ports share one memory.

// File: rtl/timl_pkg.sv
package timl_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_CTRL = 2'd1,
        K_DATA = 2'd2,
        K_TAG  = 2'd3
    } acc_kind_e;

    localparam int AUTOINC_BIT = 24;
    localparam int SECURE_BIT  = 28;
    localparam int OVF_BIT     = 29;
    localparam int BLKSEC_BIT  = 31;

    localparam int OFF_CTRL = 0;
    localparam int OFF_DATA = 4;
    localparam int OFF_TAG  = 8;

endpackage

// File: rtl/timl_bus_decode.sv
module timl_bus_decode
    import timl_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int BUS_AW    = 12,
    parameter int REG_BASE  = 'h180,
    parameter int STRIDE    = 16,
    localparam int PIW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int OFF_W    = $clog2(STRIDE)
) (
    input  logic                 req_i,
    input  logic [BUS_AW-1:0]    addr_i,
    output logic [NUM_PORTS-1:0] sel_o,
    output logic [PIW-1:0]       idx_o,
    output acc_kind_e            kind_o
);

    localparam logic [BUS_AW-1:0] BASE_A = BUS_AW'(REG_BASE);
    localparam logic [BUS_AW-1:0] SPAN_A = BUS_AW'(NUM_PORTS * STRIDE);

    logic [BUS_AW-1:0] rel;
    logic [OFF_W-1:0]  off;
    logic              in_range;

    always_comb begin
        rel      = addr_i - BASE_A;
        off      = rel[OFF_W-1:0];
        in_range = req_i && (addr_i >= BASE_A) && (rel < SPAN_A);
        idx_o    = PIW'(rel >> OFF_W);
        kind_o   = K_NONE;
        if (in_range) begin
            if (off == OFF_W'(OFF_CTRL))      kind_o = K_CTRL;
            else if (off == OFF_W'(OFF_DATA)) kind_o = K_DATA;
            else if (off == OFF_W'(OFF_TAG))  kind_o = K_TAG;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        assign sel_o[p] = (kind_o != K_NONE) && (idx_o == PIW'(p));
    end

endmodule

// File: rtl/timl_port_regs.sv
module timl_port_regs
    import timl_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int WORD_AW  = $clog2(MEM_WORDS),
    localparam int BYTE_AW  = WORD_AW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  acc_kind_e          kind_i,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    output logic [WORD_AW-1:0] addr_o,
    output logic               autoinc_o,
    output logic               secure_o,
    output logic               ovf_o
);

    localparam logic [WORD_AW-1:0] LAST_W = WORD_AW'(MEM_WORDS - 1);

    typedef struct packed {
        logic [WORD_AW-1:0] addr;
        logic               autoinc;
        logic               secure;
        logic               ovf;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            unique case (kind_i)
                K_CTRL: begin
                    if (we_i) begin
                        st_d.addr    = wdata_i[BYTE_AW-1:2];
                        st_d.autoinc = wdata_i[AUTOINC_BIT];
                        st_d.secure  = wdata_i[SECURE_BIT];
                        st_d.ovf     = 1'b0;
                    end
                end
                K_DATA: begin
                    if (st_q.autoinc) begin
                        if (st_q.addr == LAST_W) begin
                            st_d.addr = '0;
                            st_d.ovf  = 1'b1;
                        end else begin
                            st_d.addr = st_q.addr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o    = st_q.addr;
    assign autoinc_o = st_q.autoinc;
    assign secure_o  = st_q.secure;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/timl_mem_store.sv
module timl_mem_store #(
    parameter int MEM_WORDS   = 256,
    parameter int BLOCK_WORDS = 64,
    parameter int TAG_W       = 16,
    localparam int WORD_AW    = $clog2(MEM_WORDS),
    localparam int NBLK       = MEM_WORDS / BLOCK_WORDS,
    localparam int BLK_W      = $clog2(NBLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [WORD_AW-1:0] addr_i,
    input  logic [31:0]        wdata_i,
    input  logic               wsec_i,
    input  logic               tag_en_i,
    input  logic [TAG_W-1:0]   tag_i,
    output logic [31:0]        rdata_o,
    output logic [TAG_W-1:0]   rtag_o,
    output logic               rsec_o
);

    logic [31:0]      mem_q [MEM_WORDS];
    logic [TAG_W-1:0] tag_q [NBLK];
    logic [NBLK-1:0]  sec_q;
    logic [BLK_W-1:0] blk;

    assign blk = addr_i[WORD_AW-1 -: BLK_W];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) tag_q[b] <= '0;
            sec_q <= '0;
        end else begin
            if (tag_en_i) tag_q[blk] <= tag_i;
            if (wr_en_i)  sec_q[blk] <= wsec_i;
        end
    end

    assign rdata_o = mem_q[addr_i];
    assign rtag_o  = tag_q[blk];
    assign rsec_o  = sec_q[blk];

endmodule

// File: rtl/tagged_imem_load_top.sv
module tagged_imem_load_top
    import timl_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int MEM_WORDS   = 256,
    parameter int BLOCK_WORDS = 64,
    parameter int TAG_W       = 16,
    parameter int BUS_AW      = 12,
    parameter int REG_BASE    = 'h180,
    parameter int STRIDE      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [BUS_AW-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid
);

    localparam int WORD_AW = $clog2(MEM_WORDS);
    localparam int BYTE_AW = WORD_AW + 2;
    localparam int PIW     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_PORTS-1:0]              port_sel;
    logic [PIW-1:0]                    port_idx;
    acc_kind_e                         acc_kind;
    logic [NUM_PORTS-1:0][WORD_AW-1:0] port_addr;
    logic [NUM_PORTS-1:0]              port_autoinc;
    logic [NUM_PORTS-1:0]              port_secure;
    logic [NUM_PORTS-1:0]              port_ovf;

    logic [WORD_AW-1:0] cur_addr;
    logic [31:0]        mem_rdata;
    logic [TAG_W-1:0]   mem_rtag;
    logic               mem_rsec;
    logic               mem_we;
    logic               tag_we;

    timl_bus_decode #(
        .NUM_PORTS (NUM_PORTS),
        .BUS_AW    (BUS_AW),
        .REG_BASE  (REG_BASE),
        .STRIDE    (STRIDE)
    ) u_dec (
        .req_i  (host_req),
        .addr_i (host_addr),
        .sel_o  (port_sel),
        .idx_o  (port_idx),
        .kind_o (acc_kind)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        timl_port_regs #(.MEM_WORDS(MEM_WORDS)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_i     (port_sel[p]),
            .kind_i    (acc_kind),
            .we_i      (host_we),
            .wdata_i   (host_wdata),
            .addr_o    (port_addr[p]),
            .autoinc_o (port_autoinc[p]),
            .secure_o  (port_secure[p]),
            .ovf_o     (port_ovf[p])
        );
    end

    assign cur_addr = port_addr[port_idx];
    assign mem_we   = host_we && (acc_kind == K_DATA);
    assign tag_we   = host_we && (acc_kind == K_TAG);

    timl_mem_store #(
        .MEM_WORDS   (MEM_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS),
        .TAG_W       (TAG_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (mem_we),
        .addr_i   (cur_addr),
        .wdata_i  (host_wdata),
        .wsec_i   (port_secure[port_idx]),
        .tag_en_i (tag_we),
        .tag_i    (host_wdata[TAG_W-1:0]),
        .rdata_o  (mem_rdata),
        .rtag_o   (mem_rtag),
        .rsec_o   (mem_rsec)
    );

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = '0;
        rsp_d.rvalid = host_req && !host_we;
        if (host_req && !host_we) begin
            unique case (acc_kind)
                K_CTRL: begin
                    rsp_d.rdata[BYTE_AW-1:2] = cur_addr;
                    rsp_d.rdata[AUTOINC_BIT] = port_autoinc[port_idx];
                    rsp_d.rdata[SECURE_BIT]  = port_secure[port_idx];
                    rsp_d.rdata[OVF_BIT]     = port_ovf[port_idx];
                end
                K_DATA: rsp_d.rdata = mem_rdata;
                K_TAG: begin
                    rsp_d.rdata[TAG_W-1:0]  = mem_rtag;
                    rsp_d.rdata[BLKSEC_BIT] = mem_rsec;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign host_rdata  = rsp_q.rdata;
    assign host_rvalid = rsp_q.rvalid;

endmodule

// File: rtl/timl_checker.sv
module timl_checker
    import timl_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int MEM_WORDS = 256,
    localparam int WORD_AW  = $clog2(MEM_WORDS)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              host_req,
    input logic                              host_we,
    input logic                              host_rvalid,
    input logic [31:0]                       host_rdata,
    input logic [NUM_PORTS-1:0]              port_sel,
    input acc_kind_e                         acc_kind,
    input logic [NUM_PORTS-1:0][WORD_AW-1:0] port_addr,
    input logic [NUM_PORTS-1:0]              port_autoinc,
    input logic [NUM_PORTS-1:0]              port_ovf
);

    localparam logic [WORD_AW-1:0] LAST_W = WORD_AW'(MEM_WORDS - 1);

    p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid);

    p_no_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_req && !host_we) |=> !host_rvalid);

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && acc_kind == K_NONE) |=> (host_rdata == 32'd0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (port_sel[p] && acc_kind == K_DATA && port_autoinc[p] && port_addr[p] != LAST_W)
            |=> (port_addr[p] == $past(port_addr[p]) + 1'b1));

        p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (port_sel[p] && acc_kind == K_DATA && port_autoinc[p] && port_addr[p] == LAST_W)
            |=> (port_addr[p] == '0 && port_ovf[p]));

        p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (port_ovf[p] && !(port_sel[p] && acc_kind == K_CTRL && host_we)) |=> port_ovf[p]);

        p_hold_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !port_sel[p] |=> $stable(port_addr[p]));
    end

endmodule

bind tagged_imem_load_top timl_checker #(
    .NUM_PORTS (NUM_PORTS),
    .MEM_WORDS (MEM_WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_rvalid  (host_rvalid),
    .host_rdata   (host_rdata),
    .port_sel     (port_sel),
    .acc_kind     (acc_kind),
    .port_addr    (port_addr),
    .port_autoinc (port_autoinc),
    .port_ovf     (port_ovf)
);

// File: tb/tagged_imem_load_top_tb_top.sv
module tagged_imem_load_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    tagged_imem_load_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a; host_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    // monitor: pop expected items as read responses arrive
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4: unexpected response act=%h exp=none", host_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: act=%h exp=%h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h180, 32'h0, "R1");
        rd(12'h190, 32'h0, "R1");
        rd(12'h188, 32'h0, "R1");
        rd(12'h198, 32'h0, "R1");

        // R2 control load, low bits ignored
        wr(12'h180, 32'h1100_0013);
        rd(12'h180, 32'h1100_0010, "R2");
        // R3 auto-increment writes
        wr(12'h184, 32'h1111_1111);
        wr(12'h184, 32'h2222_2222);
        wr(12'h184, 32'h3333_3333);
        rd(12'h180, 32'h1100_001C, "R3");

        // R4 read back with auto-increment
        wr(12'h180, 32'h0100_0010);
        rd(12'h184, 32'h1111_1111, "R4");
        rd(12'h184, 32'h2222_2222, "R4");
        rd(12'h184, 32'h3333_3333, "R4");
        rd(12'h180, 32'h0100_001C, "R4");

        // R3 no auto-increment: overwrite same word
        wr(12'h180, 32'h0000_0020);
        wr(12'h184, 32'hDDDD_DDDD);
        wr(12'h184, 32'hEEEE_EEEE);
        rd(12'h180, 32'h0000_0020, "R3");
        rd(12'h184, 32'hEEEE_EEEE, "R3");
        rd(12'h184, 32'hEEEE_EEEE, "R4");
        rd(12'h180, 32'h0000_0020, "R4");

        // R5 tag at unaligned address in block 1
        wr(12'h180, 32'h0100_0104);
        wr(12'h188, 32'h0000_BEEF);
        rd(12'h180, 32'h0100_0104, "R5");
        rd(12'h188, 32'h0000_BEEF, "R5");
        // R6 secure write marks block
        wr(12'h180, 32'h1100_0104);
        wr(12'h184, 32'h5555_5555);
        rd(12'h188, 32'h8000_BEEF, "R6");
        rd(12'h180, 32'h1100_0108, "R6");
        // R5/R6 block 0: last write there was non-secure
        wr(12'h180, 32'h0000_0000);
        wr(12'h188, 32'h0000_1234);
        rd(12'h188, 32'h0000_1234, "R5");

        // R9 zero padding overwrites
        wr(12'h180, 32'h0100_0010);
        wr(12'h184, 32'h0000_0000);
        rd(12'h180, 32'h0100_0014, "R9");
        wr(12'h180, 32'h0100_0010);
        rd(12'h184, 32'h0000_0000, "R9");

        // R7 wrap and sticky overflow
        wr(12'h180, 32'h0100_03FC);
        wr(12'h184, 32'hF0F0_F0F0);
        rd(12'h180, 32'h2100_0000, "R7");
        rd(12'h180, 32'h2100_0000, "R7");
        wr(12'h180, 32'h0100_03FC);
        rd(12'h180, 32'h0100_03FC, "R7");
        rd(12'h184, 32'hF0F0_F0F0, "R7");
        rd(12'h180, 32'h2100_0000, "R7");

        // R8 port independence and shared memory
        wr(12'h180, 32'h0100_0300);
        wr(12'h190, 32'h0100_0200);
        wr(12'h194, 32'h6666_6666);
        rd(12'h180, 32'h0100_0300, "R8");
        rd(12'h190, 32'h0100_0204, "R8");
        wr(12'h180, 32'h0000_0200);
        rd(12'h184, 32'h6666_6666, "R8");

        // R10 unmapped offsets and addresses
        wr(12'h18C, 32'hFFFF_FFFF);
        rd(12'h18C, 32'h0, "R10");
        rd(12'h1A0, 32'h0, "R10");
        wr(12'h1A0, 32'h0100_0000);
        rd(12'h180, 32'h0000_0200, "R10");
        rd(12'h184, 32'h6666_6666, "R10");

        idle();
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4: %0d responses missing act=0 exp=%0d", exp_q.size(), exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule